// File: doc/BRIEF.md
# Pulse-Width Serial Encoder for Addressable RGB LEDs

This block drives the single data wire of a chain of addressable RGB LEDs. Each LED takes a 24-bit colour word. Every bit goes out as one fixed-length slot that begins with a high pulse and ends low. A one and a zero differ only in how long the high pulse lasts. The slot length, the two high times and the latch gap are run-time configuration inputs, all counted in system clock cycles.

Pixels come from an upstream queue. The queue raises a valid flag while it holds data. The encoder takes the word on the data input and pulses a read strobe to advance the queue, so the next word is ready while the current one shifts out. When the queue is empty at the end of a pixel, the encoder holds the line low for the configured gap, which makes the chain latch its colours, and then goes back to idle. An enable input starts and stops the encoder.

Top module: `rgb_pwc_encoder`

## Requirements
- R1: A bit slot lasts `slot_len` clock cycles. A value of 0 is treated as 1.
- R2: In each slot the line is high for the first `high_one` cycles when the bit is 1, or for the first `high_zero` cycles when the bit is 0. It is low for the rest of the slot.
- R3: A pixel is 24 bits long and goes out most-significant bit first, so bit 23 leads.
- R4: `pix_pop` is a pulse one cycle long. It is high in the first cycle of a pixel's first slot, which is the cycle after the word is taken. It is never high at any other time, so each pixel sent causes exactly one pop.
- R5: If `pix_valid` is high in the last cycle of the 24th slot, the next pixel's first slot starts in the very next cycle, with no gap.
- R6: If `pix_valid` is low in the last cycle of the 24th slot, the line stays low for `gap_len` cycles (0 is treated as 1), and the encoder then spends one cycle in idle.
- R7: While `en` is low in idle, the line stays low and `pix_pop` stays low, whatever `pix_valid` does.
- R8: If `en` falls during a pixel, the current slot runs to its end. The line then stays low, no further pixel is popped, and the rest of that pixel is dropped.
- R9: While `rst_n` is low, `led_out` and `pix_pop` are low at once, without waiting for a clock edge.
- R10: In idle, if `en` and `pix_valid` are both high at a clock edge, the word is taken at that edge and its first slot starts in the next cycle. After a gap with data waiting, the low time that follows the last high pulse is therefore `slot_len - high + gap_len + 1` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables the encoder |
| pix_valid | input | 1 | Upstream queue is not empty |
| pix_data | input | 24 | Pixel word at the head of the queue |
| pix_pop | output | 1 | One-cycle strobe that advances the queue |
| slot_len | input | 10 | Length of a bit slot, in clock cycles |
| high_zero | input | 10 | High time of a 0 bit, in clock cycles |
| high_one | input | 10 | High time of a 1 bit, in clock cycles |
| gap_len | input | 16 | Latch gap after the last pixel, in clock cycles |
| led_out | output | 1 | Serial line to the LED chain |

## Verification
The bench measures every high and low run on the line and rebuilds each word from the measured high widths. A word with a lone leading one and a trailing one shows whether the bit order is correct. Random words under random timing settings, sent in bursts of one to three pixels, separate bursts sent back to back from bursts that end in a gap, because the bench counts the long low runs. A pixel queued partway through a gap pins down the gap length and the one idle cycle. Dropping the enable in mid-slot and in idle shows whether the slot is finished and whether the queue is left untouched.

// File: rtl/rgb_pwc_encoder.sv
`timescale 1ns/1ps
module rgb_pwc_encoder #(
  parameter int PIX_W = 24,
  parameter int CNT_W = 10,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_pop,
  input  logic [CNT_W-1:0] slot_len,
  input  logic [CNT_W-1:0] high_zero,
  input  logic [CNT_W-1:0] high_one,
  input  logic [GAP_W-1:0] gap_len,
  output logic             led_out
);
  localparam int IDX_W = $clog2(PIX_W);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP} st_t;

  st_t              st;
  logic [PIX_W-1:0] shreg;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [GAP_W-1:0] gcnt;

  wire [CNT_W:0]   cnt_nx   = {1'b0, cnt} + 1'b1;
  wire [GAP_W:0]   gcnt_nx  = {1'b0, gcnt} + 1'b1;
  wire             slot_end = cnt_nx >= {1'b0, slot_len};
  wire             gap_end  = gcnt_nx >= {1'b0, gap_len};
  wire             last_bit = idx == IDX_W'(PIX_W - 1);
  wire [CNT_W-1:0] hi_sel   = shreg[PIX_W-1] ? high_one : high_zero;
  wire             load     = en && pix_valid &&
                              (st == S_IDLE || (st == S_SEND && slot_end && last_bit));

  assign led_out = (st == S_SEND) && (cnt < hi_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      shreg   <= '0;
      idx     <= '0;
      cnt     <= '0;
      gcnt    <= '0;
      pix_pop <= 1'b0;
    end else begin
      pix_pop <= load;
      if (load) begin
        st    <= S_SEND;
        shreg <= pix_data;
        idx   <= '0;
        cnt   <= '0;
      end else begin
        case (st)
          S_SEND: begin
            if (!slot_end) begin
              cnt <= cnt_nx[CNT_W-1:0];
            end else if (!en) begin
              st <= S_IDLE;
            end else if (last_bit) begin
              st   <= S_GAP;
              gcnt <= '0;
            end else begin
              shreg <= {shreg[PIX_W-2:0], 1'b0};
              idx   <= idx + 1'b1;
              cnt   <= '0;
            end
          end
          S_GAP: begin
            if (gap_end) st <= S_IDLE;
            else         gcnt <= gcnt_nx[GAP_W-1:0];
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rgb_pwc_encoder_chk.sv
`timescale 1ns/1ps
module rgb_pwc_encoder_chk #(
  parameter int PIX_W = 24,
  parameter int CNT_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en,
  input logic                     pix_valid,
  input logic                     pix_pop,
  input logic                     led_out,
  input logic [CNT_W-1:0]         high_zero,
  input logic [CNT_W-1:0]         high_one,
  input logic [$clog2(PIX_W)-1:0] idx
);
  assert_pop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_pop |=> !pix_pop);

  assert_pop_line_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_pop && high_zero != '0 && high_one != '0) |-> led_out);

  assert_pop_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_pop |-> $past(en && pix_valid));

  assert_rise_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(led_out) && $stable(high_zero) && $stable(high_one)) |-> $past(en));

  assert_bit_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx < ($clog2(PIX_W))'(PIX_W));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> (!led_out && !pix_pop));
endmodule

bind rgb_pwc_encoder rgb_pwc_encoder_chk #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pix_valid(pix_valid), .pix_pop(pix_pop),
  .led_out(led_out), .high_zero(high_zero), .high_one(high_one), .idx(idx)
);

// File: tb/sim_rgb_pwc_encoder.sv
`timescale 1ns/1ps
module sim_rgb_pwc_encoder;
  logic clk = 1'b0;
  logic rst_n, en;
  logic pix_pop, led_out;
  logic [23:0] pix_data;
  logic pix_valid;
  int P, H0, H1, G;

  logic [23:0] fifo_mem [0:63];
  logic [23:0] exp_mem  [0:255];
  int wr_ptr = 0, rd_ptr = 0;

  int total = 0, bad = 0;
  int rx_cnt = 0, bitcnt = 0, gaps = 0, rises = 0, falls = 0;
  int hcnt = 0, lcnt = 0, last_h = 0;
  bit prev_led = 0, have_bit = 0, exact_gap = 0, finished = 0;
  logic [23:0] word;

  always #4 clk = ~clk;

  assign pix_valid = wr_ptr != rd_ptr;
  assign pix_data  = fifo_mem[rd_ptr % 64];

  rgb_pwc_encoder u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_pop(pix_pop), .slot_len(10'(P)), .high_zero(10'(H0)), .high_one(10'(H1)),
    .gap_len(16'(G)), .led_out(led_out)
  );

  always @(posedge clk) if (pix_pop && pix_valid) rd_ptr <= rd_ptr + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_led = 0; have_bit = 0; hcnt = 0; lcnt = 0;
    end else begin
      if (pix_pop) chk(led_out, "R4 pop not in first slot cycle", int'(led_out), 1);
      if (led_out) begin
        if (!prev_led) begin
          rises++;
          if (have_bit) begin
            int base;
            base = P - last_h;
            total++;
            if (lcnt == base) begin
            end else if (bitcnt == 0 && lcnt >= base + G + 1 &&
                         (!exact_gap || lcnt == base + G + 1)) begin
              gaps++;
            end else begin
              bad++;
              $display("FAIL R1/R6 low run act=%0d exp=%0d", lcnt,
                       exact_gap ? base + G + 1 : base);
            end
          end
          hcnt = 1;
        end else hcnt++;
      end else begin
        if (prev_led) begin
          bit b;
          falls++;
          total++;
          if (hcnt == H1) b = 1'b1;
          else if (hcnt == H0) b = 1'b0;
          else begin
            b = 1'b0;
            bad++;
            $display("FAIL R2 high width act=%0d exp=%0d or %0d", hcnt, H0, H1);
          end
          last_h = hcnt; have_bit = 1;
          word = {word[22:0], b};
          bitcnt++;
          if (bitcnt == 24) begin
            chk(word == exp_mem[rx_cnt % 256], "R3 rebuilt word", int'(word),
                int'(exp_mem[rx_cnt % 256]));
            rx_cnt++;
            bitcnt = 0;
          end
          lcnt = 1;
        end else lcnt++;
      end
      prev_led = led_out;
    end
  end

  task automatic push(input logic [23:0] d);
    fifo_mem[wr_ptr % 64] = d;
    exp_mem[wr_ptr % 256] = d;
    wr_ptr++;
  endtask

  task automatic resync();
    @(posedge clk); #1;
    rx_cnt = rd_ptr; bitcnt = 0; have_bit = 0;
  endtask

  task automatic wait_rx(input int n, input string tag);
    int k;
    k = 0;
    while (rx_cnt < n && k < 40000) begin @(negedge clk); k++; end
    chk(rx_cnt >= n, tag, rx_cnt, n);
  endtask

  task automatic set_cfg(input int p, input int h0, input int h1, input int g);
    @(negedge clk);
    P = p; H0 = h0; H1 = h1; G = g;
    resync();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int g0, r0, f0, p0, k;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; P = 10; H0 = 3; H1 = 7; G = 20;
    repeat (3) @(negedge clk);
    chk(!led_out, "R9 line low in reset", int'(led_out), 0);
    chk(!pix_pop, "R9 pop low in reset", int'(pix_pop), 0);
    rst_n = 1'b1;

    // R3 bit order, R5 back to back inside a burst
    @(negedge clk); en = 1'b1;
    push(24'h800001); push(24'hA5C30F);
    wait_rx(2, "R3 directed pair received");
    repeat (P + G + 10) @(negedge clk);
    chk(rd_ptr == wr_ptr, "R4 one pop per pixel", rd_ptr, wr_ptr);

    // R6 and R10 exact gap length with data waiting
    set_cfg(10, 3, 7, 40);
    push(24'h5A5A5A);
    wait_rx(wr_ptr, "R6 first pixel received");
    repeat (10) @(negedge clk);
    g0 = gaps; exact_gap = 1;
    push(24'hFFFF00);
    wait_rx(wr_ptr, "R10 pixel after gap received");
    exact_gap = 0;
    chk(gaps == g0 + 1, "R6 exact gap seen", gaps - g0, 1);
    repeat (60) @(negedge clk);

    // R7 disabled: no line activity, no pop
    en = 1'b0; r0 = rises; p0 = rd_ptr;
    push(24'hFFFFFF); push(24'h123456); push(24'h0F0F0F);
    repeat (300) @(negedge clk);
    chk(rd_ptr == p0, "R7 no pop while disabled", rd_ptr, p0);
    chk(rises == r0, "R7 no pulse while disabled", rises - r0, 0);
    en = 1'b1;
    wait_rx(wr_ptr, "R7 pixels sent after enable");
    repeat (G + P + 10) @(negedge clk);

    // R8 enable dropped in the middle of a pixel
    set_cfg(20, 5, 12, 30);
    en = 1'b0;
    push(24'hFFFFFF); push(24'hC0FFEE);
    p0 = rd_ptr;
    @(negedge clk); en = 1'b1;
    k = 0;
    while (!pix_pop && k < 100) begin @(negedge clk); k++; end
    repeat (5 * 20 + 2) @(negedge clk);
    f0 = falls; en = 1'b0;
    repeat (300) @(negedge clk);
    chk(falls - f0 == 1, "R8 current slot completed", falls - f0, 1);
    chk(rd_ptr == p0 + 1, "R8 no further pop", rd_ptr, p0 + 1);
    chk(!led_out, "R8 line low after stop", int'(led_out), 0);
    resync();
    en = 1'b1;
    wait_rx(wr_ptr, "R8 queued pixel sent after re-enable");
    repeat (60) @(negedge clk);

    // R1 R2 R5 random timing and data
    for (int c = 0; c < 6; c++) begin
      int p, h0, h1, g, nb;
      p  = 8 + int'($urandom % 23);
      h0 = 1 + int'($urandom % (p / 2 - 1));
      h1 = p / 2 + int'($urandom % (p / 2));
      g  = 5 + int'($urandom % 60);
      set_cfg(p, h0, h1, g);
      g0 = gaps; nb = 3;
      for (int b = 0; b < nb; b++) begin
        int n;
        n = 1 + int'($urandom % 3);
        for (int i = 0; i < n; i++) push(24'($urandom));
        wait_rx(wr_ptr, "R1 random burst received");
        repeat (G + P + 10) @(negedge clk);
      end
      chk(gaps - g0 == nb - 1, "R5 gaps only between bursts", gaps - g0, nb - 1);
      chk(rd_ptr == wr_ptr, "R4 pops match pixels", rd_ptr, wr_ptr);
    end

    // R9 asynchronous reset in mid pixel
    push(24'hFFFFFF);
    k = 0;
    while (!pix_pop && k < 100) begin @(negedge clk); k++; end
    @(negedge clk);
    chk(led_out, "R2 line high early in slot", int'(led_out), 1);
    rst_n = 1'b0; #1;
    chk(!led_out, "R9 reset forces line low", int'(led_out), 0);
    chk(!pix_pop, "R9 reset forces pop low", int'(pix_pop), 0);
    repeat (3) @(negedge clk);
    report();
  end
endmodule